// File: doc/BRIEF.md
# Legacy Virtio Register Window

This block is the byte-addressed I/O register window of a legacy virtio function on a PCI bus. Software reads and writes it with accesses of 1, 2 or 4 bytes. The window holds:

- the feature words offered by the device and accepted from the driver;
- a queue selector, plus a page number for each queue and the size of the selected queue;
- a device status byte;
- an interrupt status byte that drives a level interrupt line.

The ring engines sit beside the block. They read the ring base addresses that the block derives for each queue. They raise interrupt causes on `isr_set`. They react to the block's single-cycle pulses: device reset, driver ready, queue init and queue notify.

Offsets at or above the device-specific window base are not decoded here. They are passed straight through on a side port. The owner of that port returns read data in the same cycle.

An access is presented for one cycle on `req_valid`. Register state and the pulses update at the clock edge that accepts the access. Read data appears on `rsp_rdata` with `rsp_valid` in the cycle after the request.

Top module: `vio_reg_window`

## Requirements
- R1: After reset, guest features, selector, status, interrupt status and all queue page numbers are zero, `irq_o` is low and no pulse is asserted.
- R2: A read at offset 0x00 returns `dev_features` ORed with bit 24 (notify-on-empty) and bit 30 (bad-feature).
- R3: A write at offset 0x04 stores `min_features` if bit 30 is set. Otherwise it stores `dev_features | (1<<24)` if any written bit lies outside that set. Otherwise it stores the written value. Offset 0x04 reads back the stored value.
- R4: A write at offset 0x0E takes the low 16 bits of the data. A value below NUM_Q selects that queue; any other value leaves the selector unchanged. Offset 0x0E reads the selector, 0x08 reads the selected queue's page number and 0x0C reads the selected queue's size.
- R5: A nonzero write at offset 0x08 stores the page number of the selected queue and pulses `qinit_pulse` with `qinit_idx` equal to the selector. For a queue with page number P and size N, the ring bases are: descriptor base D = P·4096; avail base A = D + 16·N; used base = A + 4 + 2·N, rounded up to a multiple of 4096. A queue with page number zero shows all three bases as zero.
- R6: A zero write at offset 0x08 pulses `reset_pulse` and clears guest features, selector, status, interrupt status and every page number.
- R7: A write at offset 0x12 stores the low 8 bits of the data as status. A zero value acts as the soft reset of R6. `ready_pulse` fires only when status bit 2 goes from 0 to 1.
- R8: Each bit of `isr_set` is ORed into the interrupt status byte and raises `irq_o`. A read at offset 0x13 returns the byte, then clears it and drops `irq_o`. Causes that arrive in the same cycle as that read are kept.
- R9: A write at offset 0x10 pulses `notify_pulse`, with `notify_idx` equal to the low 16 bits of the data, only when that index is below NUM_Q and the queue has a nonzero page number.
- R10: A read below offset 0x14 that hits no register (0x10 included) returns all ones. An access at 0x14 or above appears in the same cycle on the side port with offset minus 0x14, and a read there returns `cfg_rdata`.
- R11: The access size code is 0 for 1 byte, 1 for 2 bytes and 2 or 3 for 4 bytes. Write data and read data are masked to that many low bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 8 | Byte offset in the window |
| req_size | input | 2 | Access size code (R11) |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data, right-aligned |
| dev_features | input | 32 | Feature bits the device supports |
| min_features | input | 32 | Fallback feature set |
| q_size_i | input | NUM_Q*QSZ_W | Ring size of each queue, queue 0 in the low bits |
| isr_set | input | 8 | Interrupt causes to OR into the status byte |
| irq_o | output | 1 | Level interrupt line |
| cfg_valid | output | 1 | Side-port access strobe |
| cfg_write | output | 1 | Side-port write flag |
| cfg_offset | output | 8 | Offset relative to 0x14 |
| cfg_size | output | 2 | Side-port size code |
| cfg_wdata | output | 32 | Side-port write data |
| cfg_rdata | input | 32 | Side-port read data, same cycle |
| reset_pulse | output | 1 | Soft device reset pulse |
| ready_pulse | output | 1 | Driver-ready pulse |
| qinit_pulse | output | 1 | Queue initialised pulse |
| qinit_idx | output | SEL_W | Queue that was initialised |
| notify_pulse | output | 1 | Queue notify pulse |
| notify_idx | output | SEL_W | Queue that was notified |
| desc_base_o | output | NUM_Q*ADDR_W | Descriptor base of each queue |
| avail_base_o | output | NUM_Q*ADDR_W | Avail ring base of each queue |
| used_base_o | output | NUM_Q*ADDR_W | Used ring base of each queue |

## Verification
The bench builds the block with NUM_Q = 3. Because 3 is not a power of two, the out-of-range selector and notify value 3 still fits in the selector field. This exercises the range compare itself rather than a truncation.

The three queues get sizes of 128, 256 and 64. With these sizes the used-ring rounding lands on different page offsets, so the layout arithmetic of R5 is checked with unequal terms.

The feature inputs are given distinct values so that each of the three negotiation outcomes can be told apart on readback.

// File: rtl/vio_reg_pkg.sv
package vio_reg_pkg;

    // Register offsets in the window
    localparam logic [7:0] OFF_HOST   = 8'h00;
    localparam logic [7:0] OFF_GUEST  = 8'h04;
    localparam logic [7:0] OFF_PFN    = 8'h08;
    localparam logic [7:0] OFF_QSIZE  = 8'h0C;
    localparam logic [7:0] OFF_QSEL   = 8'h0E;
    localparam logic [7:0] OFF_NOTIFY = 8'h10;
    localparam logic [7:0] OFF_STATUS = 8'h12;
    localparam logic [7:0] OFF_ISR    = 8'h13;
    localparam logic [7:0] OFF_CFG    = 8'h14;

    // Bit positions
    localparam int FEAT_EMPTY_BIT = 24;
    localparam int FEAT_BAD_BIT   = 30;
    localparam int STAT_READY_BIT = 2;

    typedef enum logic [1:0] {
        ACC_B1 = 2'd0,
        ACC_B2 = 2'd1,
        ACC_B4 = 2'd2,
        ACC_B4X = 2'd3
    } acc_size_e;

    function automatic logic [31:0] size_mask(input logic [1:0] sz);
        case (acc_size_e'(sz))
            ACC_B1:  size_mask = 32'h0000_00FF;
            ACC_B2:  size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/vio_feat_neg.sv
module vio_feat_neg
    import vio_reg_pkg::*;
(
    input  logic [31:0] dev_feat,
    input  logic [31:0] min_feat,
    input  logic [31:0] wr_val,
    output logic [31:0] host_adv,
    output logic [31:0] chosen
);
    logic [31:0] host_set;

    always_comb begin
        host_set = dev_feat | (32'd1 << FEAT_EMPTY_BIT);
        host_adv = host_set | (32'd1 << FEAT_BAD_BIT);
        if (wr_val[FEAT_BAD_BIT])
            chosen = min_feat;
        else if ((wr_val & ~host_set) != 32'd0)
            chosen = host_set;
        else
            chosen = wr_val;
    end
endmodule

// File: rtl/vio_ring_layout.sv
module vio_ring_layout #(
    parameter int PFN_W      = 32,
    parameter int QSZ_W      = 16,
    parameter int PAGE_SHIFT = 12,
    localparam int ADDR_W    = PFN_W + PAGE_SHIFT
) (
    input  logic [PFN_W-1:0]  pfn,
    input  logic [QSZ_W-1:0]  qsize,
    output logic [ADDR_W-1:0] desc_base,
    output logic [ADDR_W-1:0] avail_base,
    output logic [ADDR_W-1:0] used_base
);
    localparam int DESC_SHIFT  = 4;   // 16-byte descriptors
    localparam int AVAIL_SHIFT = 1;   // 2-byte avail entries
    localparam logic [ADDR_W-1:0] AVAIL_HDR = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] PG_LOW    = ADDR_W'((64'd1 << PAGE_SHIFT) - 64'd1);

    logic [ADDR_W-1:0] size_ext, avail_end;

    always_comb begin
        size_ext   = ADDR_W'(qsize);
        desc_base  = '0;
        avail_base = '0;
        used_base  = '0;
        avail_end  = '0;
        if (pfn != '0) begin
            desc_base  = {pfn, {PAGE_SHIFT{1'b0}}};
            avail_base = desc_base + (size_ext << DESC_SHIFT);
            avail_end  = avail_base + AVAIL_HDR + (size_ext << AVAIL_SHIFT);
            used_base  = (avail_end + PG_LOW) & ~PG_LOW;
        end
    end
endmodule

// File: rtl/vio_reg_window.sv
module vio_reg_window
    import vio_reg_pkg::*;
#(
    parameter int NUM_Q      = 4,
    parameter int PFN_W      = 32,
    parameter int QSZ_W      = 16,
    parameter int PAGE_SHIFT = 12,
    localparam int SEL_W     = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int ADDR_W    = PFN_W + PAGE_SHIFT
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [7:0]                req_addr,
    input  logic [1:0]                req_size,
    input  logic [31:0]               req_wdata,
    output logic                      rsp_valid,
    output logic [31:0]               rsp_rdata,
    input  logic [31:0]               dev_features,
    input  logic [31:0]               min_features,
    input  logic [NUM_Q*QSZ_W-1:0]    q_size_i,
    input  logic [7:0]                isr_set,
    output logic                      irq_o,
    output logic                      cfg_valid,
    output logic                      cfg_write,
    output logic [7:0]                cfg_offset,
    output logic [1:0]                cfg_size,
    output logic [31:0]               cfg_wdata,
    input  logic [31:0]               cfg_rdata,
    output logic                      reset_pulse,
    output logic                      ready_pulse,
    output logic                      qinit_pulse,
    output logic [SEL_W-1:0]          qinit_idx,
    output logic                      notify_pulse,
    output logic [SEL_W-1:0]          notify_idx,
    output logic [NUM_Q*ADDR_W-1:0]   desc_base_o,
    output logic [NUM_Q*ADDR_W-1:0]   avail_base_o,
    output logic [NUM_Q*ADDR_W-1:0]   used_base_o
);
    typedef struct packed {
        logic [31:0]                  guest;
        logic [SEL_W-1:0]             sel;
        logic [7:0]                   status;
        logic [7:0]                   isr;
        logic                         irq;
        logic [NUM_Q-1:0][PFN_W-1:0]  pfn;
        logic                         rsp_v;
        logic [31:0]                  rsp_d;
        logic                         rst_p;
        logic                         rdy_p;
        logic                         qin_p;
        logic [SEL_W-1:0]             qin_i;
        logic                         ntf_p;
        logic [SEL_W-1:0]             ntf_i;
    } state_t;

    state_t st_q, st_d;

    logic [31:0] host_adv, neg_val, wmask, wval, rd_val;
    logic [15:0] low16;
    logic        is_rd, is_wr, in_cfg;
    logic [PFN_W-1:0] sel_pfn;
    logic [QSZ_W-1:0] sel_qsize;

    vio_feat_neg u_neg (
        .dev_feat (dev_features),
        .min_feat (min_features),
        .wr_val   (wval),
        .host_adv (host_adv),
        .chosen   (neg_val)
    );

    for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_ring
        vio_ring_layout #(
            .PFN_W      (PFN_W),
            .QSZ_W      (QSZ_W),
            .PAGE_SHIFT (PAGE_SHIFT)
        ) u_lay (
            .pfn        (st_q.pfn[gi]),
            .qsize      (q_size_i[gi*QSZ_W +: QSZ_W]),
            .desc_base  (desc_base_o[gi*ADDR_W +: ADDR_W]),
            .avail_base (avail_base_o[gi*ADDR_W +: ADDR_W]),
            .used_base  (used_base_o[gi*ADDR_W +: ADDR_W])
        );
    end

    // Side port passes through in the request cycle
    assign in_cfg     = req_addr >= OFF_CFG;
    assign cfg_valid  = req_valid && in_cfg;
    assign cfg_write  = req_write;
    assign cfg_offset = req_addr - OFF_CFG;
    assign cfg_size   = req_size;
    assign cfg_wdata  = wval;

    always_comb begin
        st_d      = st_q;
        wmask     = size_mask(req_size);
        wval      = req_wdata & wmask;
        low16     = wval[15:0];
        is_rd     = req_valid && !req_write;
        is_wr     = req_valid && req_write;
        sel_pfn   = st_q.pfn[st_q.sel];
        sel_qsize = q_size_i[st_q.sel*QSZ_W +: QSZ_W];

        st_d.rst_p = 1'b0;
        st_d.rdy_p = 1'b0;
        st_d.qin_p = 1'b0;
        st_d.ntf_p = 1'b0;
        st_d.rsp_v = is_rd;
        st_d.isr   = st_q.isr | isr_set;
        st_d.irq   = st_q.irq | (isr_set != 8'd0);

        case (req_addr)
            OFF_HOST:   rd_val = host_adv;
            OFF_GUEST:  rd_val = st_q.guest;
            OFF_PFN:    rd_val = 32'(sel_pfn);
            OFF_QSIZE:  rd_val = 32'(sel_qsize);
            OFF_QSEL:   rd_val = 32'(st_q.sel);
            OFF_STATUS: rd_val = {24'd0, st_q.status};
            OFF_ISR:    rd_val = {24'd0, st_q.isr};
            default:    rd_val = in_cfg ? cfg_rdata : 32'hFFFF_FFFF;
        endcase
        st_d.rsp_d = is_rd ? (rd_val & wmask) : st_q.rsp_d;

        if (is_rd && req_addr == OFF_ISR) begin
            st_d.isr = isr_set;
            st_d.irq = (isr_set != 8'd0);
        end

        if (is_wr) begin
            case (req_addr)
                OFF_GUEST: st_d.guest = neg_val;
                OFF_PFN: begin
                    if (wval != 32'd0) begin
                        st_d.pfn[st_q.sel] = wval[PFN_W-1:0];
                        st_d.qin_p = 1'b1;
                        st_d.qin_i = st_q.sel;
                    end else begin
                        st_d.rst_p = 1'b1;
                    end
                end
                OFF_QSEL: begin
                    if (low16 < 16'(NUM_Q))
                        st_d.sel = low16[SEL_W-1:0];
                end
                OFF_NOTIFY: begin
                    if (low16 < 16'(NUM_Q) && st_q.pfn[low16[SEL_W-1:0]] != '0) begin
                        st_d.ntf_p = 1'b1;
                        st_d.ntf_i = low16[SEL_W-1:0];
                    end
                end
                OFF_STATUS: begin
                    st_d.status = wval[7:0];
                    if (wval[7:0] == 8'd0)
                        st_d.rst_p = 1'b1;
                    else if (!st_q.status[STAT_READY_BIT] && wval[STAT_READY_BIT])
                        st_d.rdy_p = 1'b1;
                end
                default: ;
            endcase
        end

        // Soft reset clears all register state; same-cycle causes survive
        if (st_d.rst_p) begin
            st_d.guest  = '0;
            st_d.sel    = '0;
            st_d.status = '0;
            st_d.pfn    = '0;
            st_d.isr    = isr_set;
            st_d.irq    = (isr_set != 8'd0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid    = st_q.rsp_v;
    assign rsp_rdata    = st_q.rsp_d;
    assign irq_o        = st_q.irq;
    assign reset_pulse  = st_q.rst_p;
    assign ready_pulse  = st_q.rdy_p;
    assign qinit_pulse  = st_q.qin_p;
    assign qinit_idx    = st_q.qin_i;
    assign notify_pulse = st_q.ntf_p;
    assign notify_idx   = st_q.ntf_i;

    // R4: selector never leaves the queue range
    p_sel_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        32'(st_q.sel) < NUM_Q);

    // R5: an init pulse names a queue that now has a page number
    p_qinit_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        qinit_pulse |-> st_q.pfn[qinit_idx] != '0);

    // R6: a soft reset leaves the register state cleared
    p_reset_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |-> (st_q.status == 8'd0 && st_q.sel == '0 &&
                         st_q.guest == 32'd0 && st_q.pfn == '0));

    // R7: ready pulse only on a 0-to-1 edge of the ready bit
    p_ready_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready_pulse |-> (st_q.status[STAT_READY_BIT] && !$past(st_q.status[STAT_READY_BIT])));

    // R8: the line follows the cause byte
    p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (st_q.isr != 8'd0));

    // R8: an ISR read with no new cause drops the line
    p_isr_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == OFF_ISR && isr_set == 8'd0) |=> !irq_o);

    // R9: notify only reaches a configured queue
    p_notify_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        notify_pulse |-> st_q.pfn[notify_idx] != '0);

endmodule

// File: tb/vio_reg_window_test.sv
module vio_reg_window_test;
    localparam int NQ = 3;
    localparam int PW = 32;
    localparam int QW = 16;
    localparam int PS = 12;
    localparam int SW = 2;
    localparam int AW = PW + PS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [31:0] dev_features = 32'h0000_0021;
    logic [31:0] min_features = 32'h0000_0001;
    logic [NQ*QW-1:0] q_size_i = {16'd64, 16'd256, 16'd128};
    logic [7:0]  isr_set = '0;
    logic        irq_o;
    logic        cfg_valid, cfg_write;
    logic [7:0]  cfg_offset;
    logic [1:0]  cfg_size;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic        reset_pulse, ready_pulse, qinit_pulse, notify_pulse;
    logic [SW-1:0] qinit_idx, notify_idx;
    logic [NQ*AW-1:0] desc_base_o, avail_base_o, used_base_o;

    assign cfg_rdata = 32'hA500_0000 | {24'd0, cfg_offset};

    vio_reg_window #(.NUM_Q(NQ), .PFN_W(PW), .QSZ_W(QW), .PAGE_SHIFT(PS)) uut (.*);

    always #5 clk = ~clk;

    int checks = 0, failures = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    // snapshots
    logic s_rst, s_rdy, s_qin, s_ntf, s_cv, s_cw;
    logic [SW-1:0] s_qi, s_ni;
    logic [7:0] s_co;
    logic [31:0] s_cd;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares read responses against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) chk("R10 unexpected response", 64'd1, 64'd0);
            else chk(tag_q.pop_front(), {32'd0, rsp_rdata}, {32'd0, exp_q.pop_front()});
        end
    end

    task automatic rd(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] exp,
                      input string tag, input logic [7:0] cause = 8'd0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz; isr_set = cause;
        exp_q.push_back(exp); tag_q.push_back(tag);
        #1; s_cv = cfg_valid; s_co = cfg_offset;
        @(negedge clk);
        req_valid = 1'b0; isr_set = 8'd0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
        #1; s_cv = cfg_valid; s_cw = cfg_write; s_co = cfg_offset; s_cd = cfg_wdata;
        @(negedge clk);
        s_rst = reset_pulse; s_rdy = ready_pulse; s_qin = qinit_pulse; s_qi = qinit_idx;
        s_ntf = notify_pulse; s_ni = notify_idx;
        req_valid = 1'b0;
    endtask

    task automatic raise(input logic [7:0] c);
        @(negedge clk); isr_set = c;
        @(negedge clk); isr_set = 8'd0;
    endtask

    function automatic logic [AW-1:0] lay(input int which, input logic [PW-1:0] p, input int n);
        logic [AW-1:0] d, a, u;
        d = AW'(p) << PS;
        a = d + AW'(16 * n);
        u = ((a + AW'(4 + 2 * n) + AW'(4095)) >> PS) << PS;
        if (p == 0) return '0;
        return (which == 0) ? d : (which == 1) ? a : u;
    endfunction

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", irq_o, 0);
        chk("R1 pulses", {reset_pulse, ready_pulse, qinit_pulse, notify_pulse}, 0);
        rd(8'h04, 2, 32'h0, "R1 guest");
        rd(8'h12, 0, 32'h0, "R1 status");
        rd(8'h13, 0, 32'h0, "R1 isr");
        rd(8'h0E, 1, 32'h0, "R1 sel");
        rd(8'h08, 2, 32'h0, "R1 pfn");
        // R2
        rd(8'h00, 2, 32'h4100_0021, "R2 host features");
        // R3 negotiation
        wr(8'h04, 2, 32'h0100_0020); rd(8'h04, 2, 32'h0100_0020, "R3 accepted");
        wr(8'h04, 2, 32'h0000_0100); rd(8'h04, 2, 32'h0100_0021, "R3 unsupported");
        wr(8'h04, 2, 32'h4000_0020); rd(8'h04, 2, 32'h0000_0001, "R3 bad bit");
        // R11 write masking then read masking
        wr(8'h04, 1, 32'h4000_0020); rd(8'h04, 2, 32'h0000_0020, "R11 2-byte write");
        rd(8'h00, 0, 32'h0000_0021, "R11 1-byte read");
        // R4 selector
        wr(8'h0E, 1, 32'd2); rd(8'h0E, 1, 32'd2, "R4 select 2");
        wr(8'h0E, 1, 32'd3); rd(8'h0E, 1, 32'd2, "R4 out of range ignored");
        rd(8'h0C, 1, 32'd64, "R4 size q2");
        wr(8'h0E, 2, 32'h0001_0000); rd(8'h0E, 1, 32'd0, "R4 low 16 bits");
        rd(8'h0C, 1, 32'd128, "R4 size q0");
        // R5 page numbers
        wr(8'h08, 2, 32'd5);
        chk("R5 qinit", {s_qin, s_qi}, {1'b1, 2'd0});
        rd(8'h08, 2, 32'd5, "R5 pfn readback");
        chk("R5 desc q0", desc_base_o[0 +: AW], lay(0, 5, 128));
        chk("R5 avail q0", avail_base_o[0 +: AW], lay(1, 5, 128));
        chk("R5 used q0", used_base_o[0 +: AW], lay(2, 5, 128));
        chk("R5 used q0 const", used_base_o[0 +: AW], 44'h6000);
        wr(8'h0E, 1, 32'd2); wr(8'h08, 2, 32'h10);
        chk("R5 qinit q2", {s_qin, s_qi}, {1'b1, 2'd2});
        chk("R5 used q2", used_base_o[2*AW +: AW], lay(2, 32'h10, 64));
        chk("R5 q1 untouched", desc_base_o[AW +: AW], 0);
        // R9 notify
        wr(8'h10, 1, 32'd1); chk("R9 unconfigured q1", s_ntf, 0);
        wr(8'h10, 1, 32'd2); chk("R9 notify q2", {s_ntf, s_ni}, {1'b1, 2'd2});
        wr(8'h10, 1, 32'd3); chk("R9 out of range", s_ntf, 0);
        wr(8'h10, 1, 32'd0); chk("R9 notify q0", {s_ntf, s_ni}, {1'b1, 2'd0});
        // R7 status
        wr(8'h12, 0, 32'd1); chk("R7 no ready", s_rdy, 0);
        wr(8'h12, 0, 32'd5); chk("R7 ready edge", s_rdy, 1);
        rd(8'h12, 0, 32'd5, "R7 status readback");
        wr(8'h12, 0, 32'd7); chk("R7 ready held", s_rdy, 0);
        wr(8'h12, 2, 32'h0000_0104); chk("R7 low byte no edge", {s_rdy, s_rst}, 0);
        rd(8'h12, 0, 32'h04, "R7 low 8 bits");
        // R8 interrupt status
        raise(8'h01); chk("R8 irq raised", irq_o, 1);
        rd(8'h13, 0, 32'h01, "R8 isr value");
        chk("R8 irq dropped", irq_o, 0);
        rd(8'h13, 0, 32'h00, "R8 isr cleared");
        raise(8'h02);
        rd(8'h13, 0, 32'h02, "R8 read with new cause", 8'h01);
        chk("R8 same-cycle cause keeps irq", irq_o, 1);
        rd(8'h13, 0, 32'h01, "R8 same-cycle cause kept");
        // R10 unmapped and side port
        rd(8'h10, 2, 32'hFFFF_FFFF, "R10 notify read");
        chk("R10 no side access", s_cv, 0);
        rd(8'h01, 0, 32'h0000_00FF, "R10 unmapped byte");
        rd(8'h18, 2, 32'hA500_0004, "R10 side read");
        chk("R10 side offset", {s_cv, s_co}, {1'b1, 8'h04});
        wr(8'h15, 1, 32'hDEAD_BEEF);
        chk("R10 side write", {s_cv, s_cw, s_co, s_cd}, {1'b1, 1'b1, 8'h01, 32'h0000_BEEF});
        // R7 zero status triggers reset
        wr(8'h04, 2, 32'h20); wr(8'h0E, 1, 32'd1);
        wr(8'h12, 0, 32'd0); chk("R7 zero status reset", s_rst, 1);
        rd(8'h04, 2, 32'h0, "R6 guest cleared");
        rd(8'h0E, 1, 32'h0, "R6 sel cleared");
        chk("R6 q2 cleared", desc_base_o[2*AW +: AW], 0);
        // R6 zero page number
        wr(8'h12, 0, 32'd4); wr(8'h08, 2, 32'd7);
        raise(8'h04);
        wr(8'h08, 2, 32'd0); chk("R6 reset pulse", {s_rst, s_qin}, {1'b1, 1'b0});
        chk("R6 desc cleared", desc_base_o[0 +: AW], 0);
        chk("R6 irq cleared", irq_o, 0);
        rd(8'h12, 0, 32'h0, "R6 status cleared");
        wr(8'h10, 1, 32'd0); chk("R6 notify after reset", s_ntf, 0);
        repeat (2) @(negedge clk);
        chk("scoreboard drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule